// File: doc/BRIEF.md
# Write Completion Poller

This block sits on the controller side of a nonvolatile memory. After the controller has launched an erase or a byte program elsewhere, it pulses `start` with the target address, the data it expects to find there and a detection mode. The poller then reads that location over a simple request/acknowledge master port until the memory reports that the write has finished. It raises a one-cycle `done` together with a pass/fail verdict, or with a timeout flag if the memory never settles.

Three detection rules are available. The first compares the top data bit against the top bit of the expected byte. This rule is only meaningful when the location was erased before it was programmed. The second waits until the second-highest bit stops alternating between two consecutive reads. The third waits until two consecutive reads return the same byte. The write can finish between two reads, so a completion read can disagree with the expected byte even though the write succeeded. In that case the poller reads the location twice more and fails only if either extra read also disagrees. Issuing the erase or program command itself is left to other logic.

Top module: `wcp_poller`

## Requirements
- R1: A `start` pulse while the poller is idle latches `addr`, `exp_data`, `mode` and `max_reads` and begins reading `addr`; a `start` while a poll is in progress is ignored and changes neither the address read nor the result.
- R2: At most one read is in flight: `rd_req` stays high until a cycle with `rd_ack` high, each such cycle is one completed read, `rd_addr` equals the latched address throughout, and `rd_req` is low whenever the poller is idle.
- R3: In mode 2'b00 a read completes the write when its bit DW-1 equals bit DW-1 of the expected data; the first read can complete it.
- R4: In mode 2'b01 a read completes the write when its bit DW-2 equals bit DW-2 of the previous read of the same poll; the first read never completes it.
- R5: In modes 2'b10 and 2'b11 a read completes the write when it equals the previous read of the same poll in every bit; the first read never completes it.
- R6: When the completing read equals the expected data in every bit, the poll ends with `pass` high and no further reads.
- R7: When the completing read differs from the expected data, exactly two more reads follow; `pass` is high only if both equal the expected data, otherwise the poll ends with `pass` low and `timeout` low.
- R8: If the number of non-completing reads reaches `max_reads` (0 acts as 1), the poll ends with `timeout` high and `pass` low; the two confirming reads of R7 do not count toward this limit.
- R9: `done` is high for exactly one cycle per poll; `pass` and `timeout` keep their values after `done` until the next accepted `start`, which clears them.
- R10: While `rst_n` is low, `done`, `pass`, `timeout` and `rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a poll (accepted when idle) |
| addr | input | AW | Location to poll |
| exp_data | input | DW | Data the finished write should leave |
| mode | input | 2 | 00 top-bit, 01 toggle-bit, 1x identical reads |
| max_reads | input | CW | Limit on non-completing reads |
| rd_req | output | 1 | Read request to the memory bus |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read completed this cycle |
| rd_data | input | DW | Read data, valid with `rd_ack` |
| done | output | 1 | One-cycle end-of-poll pulse |
| pass | output | 1 | Write confirmed good |
| timeout | output | 1 | Read limit reached without completion |

## Verification
The bench builds the poller with a 12-bit address, 8-bit data and a 4-bit read limit. The sweep covers every mode, zero to five busy reads before completion, limits of 0, 3 and 6, and four endings: clean, a late read settling during confirmation, and failures in either confirming read. With these small limits, the cases where completion falls exactly on the limit, one read past it, and on a limit of zero all come up. Varying bus latency and a stray `start` in mid-poll test the single-outstanding-read and ignore rules.

// File: rtl/wcp_pkg.sv
// Shared types for the write completion poller.
package wcp_pkg;

    // Detection rule selected per poll; both 1x codes use identical-read matching.
    typedef enum logic [1:0] {
        MODE_TOPBIT  = 2'b00,
        MODE_TOGGLE  = 2'b01,
        MODE_SAME    = 2'b10,
        MODE_SAME_B  = 2'b11
    } poll_mode_e;

    // Sequencer phases.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_CONF_A,
        ST_CONF_B
    } poll_state_e;

endpackage

// File: rtl/wcp_done_eval.sv
// Completion evaluator.
// Decides, for the data of one read, whether the memory reports the write
// as finished under the selected rule, and whether the data equals the
// expected byte. Purely combinational; assumes DW >= 2.
module wcp_done_eval
    import wcp_pkg::*;
#(
    parameter int DW = 8
) (
    input  poll_mode_e      mode,
    input  logic [DW-1:0]   rdata,
    input  logic [DW-1:0]   prev,
    input  logic            have_prev,
    input  logic [DW-1:0]   expect_q,
    output logic            complete,
    output logic            exact
);
    localparam int TOP_BIT = DW - 1;
    localparam int TGL_BIT = DW - 2;

    // Apply the selected completion rule to the current read.
    always_comb begin
        unique case (mode)
            MODE_TOPBIT: complete = (rdata[TOP_BIT] == expect_q[TOP_BIT]);
            MODE_TOGGLE: complete = have_prev && (rdata[TGL_BIT] == prev[TGL_BIT]);
            default:     complete = have_prev && (rdata == prev);
        endcase
    end

    // Full-width comparison against the expected byte.
    always_comb exact = (rdata == expect_q);

endmodule

// File: rtl/wcp_history.sv
// Previous-read register.
// Holds the data of the last scanning read of the current poll and flags
// whether one exists. Cleared when a poll is accepted.
module wcp_history #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            load,
    input  logic [DW-1:0]   din,
    output logic [DW-1:0]   prev,
    output logic            have_prev
);
    // Capture each scanning read; forget history on a new poll.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prev      <= '0;
            have_prev <= 1'b0;
        end else if (load) begin
            prev      <= din;
            have_prev <= 1'b1;
        end
    end

endmodule

// File: rtl/wcp_read_budget.sv
// Read budget counter.
// Counts non-completing scanning reads and reports when the read now being
// judged would reach the limit. A limit of zero behaves as one. Assumes the
// counter is cleared at poll start and never incremented past the limit.
module wcp_read_budget #(
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            inc,
    input  logic [CW-1:0]   limit,
    output logic            at_limit
);
    logic [CW-1:0] used_q;
    logic [CW:0]   next_used;

    // Count the reads spent so far in this poll.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) used_q <= '0;
        else if (inc)        used_q <= used_q + 1'b1;
    end

    // The read under judgement is number used_q + 1.
    always_comb begin
        next_used = {1'b0, used_q} + {{CW{1'b0}}, 1'b1};
        at_limit  = (next_used >= {1'b0, limit});
    end

endmodule

// File: rtl/wcp_poller.sv
// Write completion poller (top).
// Repeatedly reads one location through a request/ack master port until the
// selected rule reports the write finished, confirms a disagreeing result
// with two extra reads, and reports done with pass or timeout. Assumes the
// bus answers each request with a single-cycle ack carrying the data.
module wcp_poller
    import wcp_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   exp_data,
    input  logic [1:0]      mode,
    input  logic [CW-1:0]   max_reads,
    output logic            rd_req,
    output logic [AW-1:0]   rd_addr,
    input  logic            rd_ack,
    input  logic [DW-1:0]   rd_data,
    output logic            done,
    output logic            pass,
    output logic            timeout
);
    poll_state_e    state_q;
    poll_mode_e     mode_q;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  exp_q;
    logic [CW-1:0]  limit_q;
    logic           conf_a_ok_q;

    logic           accept;
    logic           scan_ack;
    logic           complete;
    logic           exact;
    logic           at_limit;
    logic [DW-1:0]  prev;
    logic           have_prev;

    // Handshake qualifiers shared by the sub-blocks.
    always_comb begin
        accept   = start && (state_q == ST_IDLE);
        scan_ack = rd_ack && (state_q == ST_SCAN);
    end

    wcp_done_eval #(.DW(DW)) u_eval (
        .mode      (mode_q),
        .rdata     (rd_data),
        .prev      (prev),
        .have_prev (have_prev),
        .expect_q  (exp_q),
        .complete  (complete),
        .exact     (exact)
    );

    wcp_history #(.DW(DW)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .load      (scan_ack),
        .din       (rd_data),
        .prev      (prev),
        .have_prev (have_prev)
    );

    wcp_read_budget #(.CW(CW)) u_budget (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .inc      (scan_ack && !complete),
        .limit    (limit_q),
        .at_limit (at_limit)
    );

    // Latch the poll parameters when a poll is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_TOPBIT;
            addr_q  <= '0;
            exp_q   <= '0;
            limit_q <= '0;
        end else if (accept) begin
            mode_q  <= poll_mode_e'(mode);
            addr_q  <= addr;
            exp_q   <= exp_data;
            limit_q <= max_reads;
        end
    end

    // Sequence scanning, confirmation and result reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            conf_a_ok_q <= 1'b0;
            done        <= 1'b0;
            pass        <= 1'b0;
            timeout     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pass    <= 1'b0;
                        timeout <= 1'b0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (rd_ack) begin
                        if (complete && exact) begin
                            pass    <= 1'b1;
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (complete) begin
                            state_q <= ST_CONF_A;
                        end else if (at_limit) begin
                            timeout <= 1'b1;
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_CONF_A: begin
                    if (rd_ack) begin
                        conf_a_ok_q <= exact;
                        state_q     <= ST_CONF_B;
                    end
                end
                default: begin
                    if (rd_ack) begin
                        pass    <= conf_a_ok_q && exact;
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Bus request follows the active phases; address is the latched one.
    always_comb begin
        rd_req  = (state_q != ST_IDLE);
        rd_addr = addr_q;
    end

endmodule

// File: rtl/wcp_poller_chk.sv
// Assertion checker for wcp_poller, attached by bind below.
// Observes only the poller's ports and keeps its own read count per poll.
module wcp_poller_chk #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CW-1:0]   max_reads,
    input  logic            rd_req,
    input  logic [AW-1:0]   rd_addr,
    input  logic            rd_ack,
    input  logic            done,
    input  logic            pass,
    input  logic            timeout
);
    logic [CW+1:0] reads_q;
    logic [CW+1:0] lim_q;

    // Track reads since the last accepted start and the effective limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reads_q <= '0;
            lim_q   <= '0;
        end else if (start && !rd_req) begin
            reads_q <= '0;
            lim_q   <= (max_reads == '0) ? (CW+2)'(1) : (CW+2)'(max_reads);
        end else if (rd_req && rd_ack && reads_q != '1) begin
            reads_q <= reads_q + 1'b1;
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && $past(rd_req)) |-> $stable(rd_addr));

    // R1
    req_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> $past(start));

    // R8
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && timeout));

    // R8
    timeout_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> (reads_q == lim_q));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pass) |-> (done || $past(start)));

endmodule

bind wcp_poller wcp_poller_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (.*);

// File: tb/wcp_poller_bench.sv
`timescale 1ns/1ps
module wcp_poller_bench;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] exp_data = '0;
    logic [1:0]    mode = '0;
    logic [CW-1:0] max_reads = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          done, pass, timeout;

    always #2.5 clk = ~clk;

    wcp_poller #(.AW(AW), .DW(DW), .CW(CW)) u_wcp_poller (.*);

    int n_vec = 0;
    int n_bad = 0;

    // Memory model state for the current poll.
    int            k_reads;
    int            n_busy;
    int            mode_cur;
    int            lat;
    int            wcnt;
    logic [7:0]    e_cur, f_cur, c1_cur, c2_cur;
    logic [AW-1:0] a_cur;
    bit            addr_err;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Data returned by read number idx of the current poll.
    function automatic logic [7:0] resp(input int idx);
        int fin;
        fin = (mode_cur == 0) ? n_busy + 1 : n_busy + 2;
        if (idx <= n_busy)
            return {~e_cur[7], f_cur[6] ^ 1'((n_busy - idx + 1) & 1), 6'(idx)};
        else if (idx <= fin) return f_cur;
        else if (idx == fin + 1) return c1_cur;
        else if (idx == fin + 2) return c2_cur;
        return e_cur;
    endfunction

    // Bus responder: variable latency, single-cycle ack.
    initial begin
        k_reads = 0; lat = 0; wcnt = 0; addr_err = 0;
        forever begin
            @(negedge clk);
            rd_ack = 1'b0;
            if (rst_n && rd_req) begin
                if (wcnt >= lat) begin
                    k_reads++;
                    rd_data = resp(k_reads);
                    rd_ack  = 1'b1;
                    wcnt    = 0;
                    if (rd_addr !== a_cur) addr_err = 1;
                    lat = (k_reads * 7) % 3;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic run(input int md, input int nb, input int vr, input int mx,
                       input logic [7:0] e, input logic [AW-1:0] a, input bit inject);
        int  maxe, need, exp_reads, cyc;
        bit  exp_pass, exp_tmo, seen;
        int  got_reads;
        bit  got_pass, got_tmo;
        string rtag;
        mode_cur = md; n_busy = nb; e_cur = e; a_cur = a;
        f_cur  = (vr == 0) ? e : (e ^ 8'h01);
        c1_cur = (vr == 3) ? f_cur : e;
        c2_cur = (vr == 2) ? f_cur : e;
        maxe = (mx == 0) ? 1 : mx;
        need = (md == 0) ? nb + 1 : nb + 2;
        if (need > maxe) begin
            exp_tmo = 1; exp_pass = 0; exp_reads = maxe;
        end else begin
            exp_tmo = 0;
            exp_reads = need + ((f_cur != e) ? 2 : 0);
            exp_pass = (f_cur == e) || (c1_cur == e && c2_cur == e);
        end
        rtag = (md == 0) ? "R3" : (md == 1) ? "R4" : "R5";
        if (exp_tmo) rtag = "R8";
        else if (f_cur != e) rtag = {rtag, "/R7"};
        else rtag = {rtag, "/R6"};

        @(negedge clk);
        k_reads = 0; wcnt = 0; addr_err = 0;
        start = 1'b1; addr = a; exp_data = e; mode = 2'(md); max_reads = CW'(mx);
        @(negedge clk);
        start = 1'b0;
        seen = 0; got_reads = 0; got_pass = 0; got_tmo = 0;
        for (cyc = 0; cyc < 400; cyc++) begin
            @(negedge clk);
            if (inject && cyc == 2) begin
                // R1: stray start mid-poll with different parameters
                start = 1'b1; addr = a ^ 12'h001; mode = 2'(md ^ 1);
                exp_data = ~e; max_reads = '0;
            end else begin
                start = 1'b0;
            end
            if (done) begin
                seen = 1; got_reads = k_reads; got_pass = pass; got_tmo = timeout;
                break;
            end
        end
        start = 1'b0;
        chk(seen, "R9 done never seen (watchdog)", 0, 1);
        chk(got_tmo == exp_tmo, {rtag, " timeout"}, got_tmo, exp_tmo);
        chk(got_pass == exp_pass, {rtag, " pass"}, got_pass, exp_pass);
        chk(got_reads == exp_reads, {rtag, " read count"}, got_reads, exp_reads);
        chk(!addr_err, inject ? "R1 address after stray start" : "R2 read address", addr_err, 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done width", done, 0);
        chk(pass == exp_pass && timeout == exp_tmo, "R9 result hold", pass, exp_pass);
        chk(rd_req == 1'b0, "R2 idle request", rd_req, 0);
    endtask

    initial begin
        int runs;
        runs = 0;
        repeat (3) @(negedge clk);
        chk(!done && !pass && !timeout, "R10 reset outputs", done + pass + timeout, 0);
        chk(rd_req == 1'b0, "R10 reset request", rd_req, 0);
        rst_n = 1'b1;
        for (int md = 0; md < 4; md++)
            for (int nb = 0; nb < 6; nb++)
                for (int vr = 0; vr < 4; vr++)
                    for (int mi = 0; mi < 3; mi++) begin
                        int mx;
                        mx = (mi == 0) ? 0 : (mi == 1) ? 3 : 6;
                        run(md, nb, vr, mx, 8'(8'h3C + runs * 37), AW'(runs * 53 + 5),
                            (nb >= 3 && vr == 1 && mx == 6));
                        runs++;
                    end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule